// File: doc/BRIEF.md
# Priority Reference Selector with Forcing

This block chooses which of up to fifteen candidate clock inputs (nine by default, numbered from 1) feeds a timing loop as its reference. Each input has a priority value and a valid flag supplied by measurement logic outside the block. From these the block builds a ranking of the three best usable inputs and a registered selected index. The value 0 stands for "no input" in every index output.

Two policies are offered. In revertive operation the selector always moves to the best-ranked usable input. In nonrevertive operation it stays on its present reference for as long as that reference remains usable. When a better input is available but not taken, it raises a sticky pending flag that can drive an interrupt, so software can order the switchover by pulsing the revertive control. A 4-bit force code can pin one input to the head of the ranking. The normal ranking then moves down one place, and some code values suspend selection entirely.

Top module: `prio_ref_selector`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sel_o`, `rank1_o`, `rank2_o`, `rank3_o` and `upgrade_pend_o` become 0.
- R2: With force code 0 and the selector not blocked, the rank outputs list the valid inputs whose priority value is nonzero, best first. A smaller priority value ranks higher, and equal values go to the smaller input number. Unused rank places read 0. All rank and selection outputs are registered and reflect the inputs one clock edge earlier.
- R3: With `revertive_i` = 1 and no forcing, `sel_o` after an edge equals the best usable input at that edge, or 0 if there is none.
- R4: With `revertive_i` = 0, the selector keeps its current nonzero reference while that input is valid and either has a nonzero priority or is the forced input. Otherwise it moves to the best usable input.
- R5: Force code 15 behaves exactly like force code 0 (automatic selection, no forcing).
- R6: Force codes 1 to 6, 8 and 9 place the input with that number at `rank1_o`, whatever its priority or validity. The normal first and second entries, computed without the forced input, appear at `rank2_o` and `rank3_o`.
- R7: In revertive mode, a forced input that is valid is selected at the next edge. If the forced input is invalid, the normal best input is selected.
- R8: In nonrevertive mode, a forced input is selected only once the current reference stops being usable, or when none is selected.
- R9: Force codes 7 and 10 to 14 drive `sel_o` and all three rank outputs to 0.
- R10: In nonrevertive mode, when the held reference is not the best usable input, `upgrade_pend_o` becomes 1 at the next edge. It stays 1 until a cycle with `upgrade_clr_i` = 1, which clears it. A new set condition in the same cycle wins over the clear.
- R11: `irq_o` equals `upgrade_pend_o` AND `irq_en_i`, without delay.
- R12: Raising `revertive_i` for one cycle while in nonrevertive mode moves `sel_o` to the best usable input at that edge. The selection then holds after the control returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_i | input | NUM_IN*PRIO_W | Priority of each input; input n uses bits [(n-1)*PRIO_W +: PRIO_W]; 0 = not eligible |
| valid_i | input | NUM_IN | Valid flag per input; bit n-1 belongs to input n |
| revertive_i | input | 1 | 1 = revertive policy, 0 = nonrevertive |
| force_i | input | 4 | Force code |
| upgrade_clr_i | input | 1 | Write-one-to-clear strobe for the pending flag |
| irq_en_i | input | 1 | Interrupt enable |
| sel_o | output | 4 | Selected input number, 0 = none |
| rank1_o | output | 4 | First ranked input |
| rank2_o | output | 4 | Second ranked input |
| rank3_o | output | 4 | Third ranked input |
| upgrade_pend_o | output | 1 | Sticky "better input available" flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The selection, the three rank places and the pending flag are registered, so each one is due at the first rising edge after the stimulus. `irq_o` follows the pending flag and the enable in the same cycle. The bench drives each stimulus on the falling edge and keeps it stable across the next rising edge. It then compares every output 1 ns after that rising edge against values it derives from its own running copy of the selected index and the flag. The force-code sweep covers every code in both policies, and a long pseudo-random run varies validity, priorities with many ties, clears and policy changes.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
    localparam int IDX_W    = 4;
    localparam int MAX_IN   = 15;
    localparam int NUM_RANK = 3;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        FM_AUTO,
        FM_FORCED,
        FM_BLOCKED
    } fmode_e;

    typedef struct packed {
        fmode_e mode;
        idx_t   target;
    } force_info_t;

    // Map a force code to a mode and a target input number.
    function automatic force_info_t decode_force(idx_t code, logic [15:0] mask, int num_in);
        force_info_t f;
        f.mode   = FM_BLOCKED;
        f.target = '0;
        if (code == idx_t'(0) || code == idx_t'(15)) begin
            f.mode = FM_AUTO;
        end else if (mask[code] && int'(code) <= num_in) begin
            f.mode   = FM_FORCED;
            f.target = code;
        end
        return f;
    endfunction
endpackage

// File: rtl/refsel_force_decode.sv
`timescale 1ns/1ps
module refsel_force_decode
    import refsel_pkg::*;
#(
    parameter int          NUM_IN     = 9,
    parameter logic [15:0] FORCE_MASK = 16'h037E
) (
    input  idx_t        code_i,
    output force_info_t info_o
);
    always_comb begin
        info_o = decode_force(code_i, FORCE_MASK, NUM_IN);
    end
endmodule

// File: rtl/refsel_rank_pick.sv
`timescale 1ns/1ps
module refsel_rank_pick
    import refsel_pkg::*;
#(
    parameter int NUM_IN = 9,
    parameter int PRIO_W = 4
) (
    input  logic [NUM_IN*PRIO_W-1:0] prio_i,
    input  logic [NUM_IN-1:0]        cand_i,
    output idx_t                     idx_o
);
    logic [PRIO_W-1:0] best_p;
    logic              found;

    // Scan upward with a strict compare so ties keep the lower number.
    always_comb begin
        idx_o  = '0;
        best_p = '1;
        found  = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best_p)) begin
                found  = 1'b1;
                best_p = prio_i[i*PRIO_W +: PRIO_W];
                idx_o  = idx_t'(i + 1);
            end
        end
    end
endmodule

// File: rtl/refsel_next.sv
`timescale 1ns/1ps
module refsel_next
    import refsel_pkg::*;
#(
    parameter int NUM_IN = 9
) (
    input  idx_t              cur_i,
    input  force_info_t       finfo_i,
    input  logic [NUM_IN-1:0] valid_i,
    input  logic [NUM_IN-1:0] prio_nz_i,
    input  logic [NUM_IN-1:0] forced_oh_i,
    input  logic              revertive_i,
    input  idx_t              lead_i,
    output idx_t              next_o,
    output logic              pend_set_o
);
    logic cur_ok;
    logic forced_ok;
    idx_t best;

    always_comb begin
        cur_ok    = 1'b0;
        forced_ok = |(forced_oh_i & valid_i);
        for (int i = 0; i < NUM_IN; i++) begin
            if (cur_i == idx_t'(i + 1)) begin
                cur_ok = valid_i[i] && (prio_nz_i[i] || forced_oh_i[i]);
            end
        end
        best       = forced_ok ? finfo_i.target : lead_i;
        pend_set_o = 1'b0;
        if (finfo_i.mode == FM_BLOCKED) begin
            next_o = '0;
        end else if (revertive_i) begin
            next_o = best;
        end else if (cur_ok) begin
            next_o     = cur_i;
            pend_set_o = (best != cur_i);
        end else begin
            next_o = best;
        end
    end
endmodule

// File: rtl/prio_ref_selector.sv
`timescale 1ns/1ps
module prio_ref_selector
    import refsel_pkg::*;
#(
    parameter int          NUM_IN     = 9,
    parameter int          PRIO_W     = 4,
    parameter logic [15:0] FORCE_MASK = 16'h037E
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IN*PRIO_W-1:0] prio_i,
    input  logic [NUM_IN-1:0]        valid_i,
    input  logic                     revertive_i,
    input  logic [3:0]               force_i,
    input  logic                     upgrade_clr_i,
    input  logic                     irq_en_i,
    output logic [3:0]               sel_o,
    output logic [3:0]               rank1_o,
    output logic [3:0]               rank2_o,
    output logic [3:0]               rank3_o,
    output logic                     upgrade_pend_o,
    output logic                     irq_o
);
    force_info_t       finfo;
    logic [NUM_IN-1:0] prio_nz;
    logic [NUM_IN-1:0] forced_oh;
    logic [NUM_IN-1:0] cand [NUM_RANK];
    idx_t              norm [NUM_RANK];
    idx_t              rank_d [NUM_RANK];
    idx_t              rank_q [NUM_RANK];
    idx_t              sel_d;
    idx_t              sel_q;
    logic              pend_set;
    logic              pend_q;

    refsel_force_decode #(
        .NUM_IN     (NUM_IN),
        .FORCE_MASK (FORCE_MASK)
    ) u_dec (
        .code_i (force_i),
        .info_o (finfo)
    );

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        assign prio_nz[i]   = |prio_i[i*PRIO_W +: PRIO_W];
        assign forced_oh[i] = (finfo.mode == FM_FORCED) && (finfo.target == idx_t'(i + 1));
    end

    // Normal ranking: repeated minimum search, each pass removing the previous winner.
    assign cand[0] = valid_i & prio_nz & ~forced_oh;

    for (genvar r = 0; r < NUM_RANK; r++) begin : g_rank
        refsel_rank_pick #(
            .NUM_IN (NUM_IN),
            .PRIO_W (PRIO_W)
        ) u_pick (
            .prio_i (prio_i),
            .cand_i (cand[r]),
            .idx_o  (norm[r])
        );
        if (r < NUM_RANK - 1) begin : g_excl
            for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
                assign cand[r+1][i] = cand[r][i] && (norm[r] != idx_t'(i + 1));
            end
        end
    end

    // Published ranking: forced input on top, normal list shifted down.
    always_comb begin
        for (int r = 0; r < NUM_RANK; r++) begin
            rank_d[r] = '0;
        end
        case (finfo.mode)
            FM_AUTO: begin
                for (int r = 0; r < NUM_RANK; r++) begin
                    rank_d[r] = norm[r];
                end
            end
            FM_FORCED: begin
                rank_d[0] = finfo.target;
                for (int r = 1; r < NUM_RANK; r++) begin
                    rank_d[r] = norm[r-1];
                end
            end
            default: begin
            end
        endcase
    end

    refsel_next #(
        .NUM_IN (NUM_IN)
    ) u_next (
        .cur_i       (sel_q),
        .finfo_i     (finfo),
        .valid_i     (valid_i),
        .prio_nz_i   (prio_nz),
        .forced_oh_i (forced_oh),
        .revertive_i (revertive_i),
        .lead_i      (norm[0]),
        .next_o      (sel_d),
        .pend_set_o  (pend_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            pend_q <= 1'b0;
            for (int r = 0; r < NUM_RANK; r++) begin
                rank_q[r] <= '0;
            end
        end else begin
            sel_q  <= sel_d;
            pend_q <= (pend_q & ~upgrade_clr_i) | pend_set;
            for (int r = 0; r < NUM_RANK; r++) begin
                rank_q[r] <= rank_d[r];
            end
        end
    end

    assign sel_o          = sel_q;
    assign rank1_o        = rank_q[0];
    assign rank2_o        = rank_q[1];
    assign rank3_o        = rank_q[2];
    assign upgrade_pend_o = pend_q;
    assign irq_o          = pend_q & irq_en_i;
endmodule

// File: rtl/refsel_checker.sv
`timescale 1ns/1ps
module refsel_checker
    import refsel_pkg::*;
#(
    parameter int          NUM_IN     = 9,
    parameter int          PRIO_W     = 4,
    parameter logic [15:0] FORCE_MASK = 16'h037E
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_IN*PRIO_W-1:0] prio_i,
    input logic [NUM_IN-1:0]        valid_i,
    input logic                     revertive_i,
    input logic [3:0]               force_i,
    input logic                     upgrade_clr_i,
    input logic [3:0]               sel_o,
    input logic [3:0]               rank1_o,
    input logic [3:0]               rank2_o,
    input logic [3:0]               rank3_o,
    input logic                     upgrade_pend_o
);
    logic              seen;
    logic [NUM_IN-1:0] valid_q;
    logic [NUM_IN-1:0] nz_q;
    logic              rev_q;
    logic [3:0]        code_q;
    logic [3:0]        sel_prev;
    logic              auto_q;
    logic              forced_q;
    logic              blocked_q;
    logic              prev_keepable;
    logic              forced_valid_q;

    always_ff @(posedge clk) begin
        seen     <= !rst;
        valid_q  <= valid_i;
        rev_q    <= revertive_i;
        code_q   <= force_i;
        sel_prev <= sel_o;
        for (int i = 0; i < NUM_IN; i++) begin
            nz_q[i] <= |prio_i[i*PRIO_W +: PRIO_W];
        end
    end

    always_comb begin
        auto_q         = (code_q == 4'd0) || (code_q == 4'd15);
        forced_q       = !auto_q && FORCE_MASK[code_q] && (int'(code_q) <= NUM_IN);
        blocked_q      = !auto_q && !forced_q;
        prev_keepable  = 1'b0;
        forced_valid_q = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (sel_prev == 4'(i + 1)) prev_keepable = valid_q[i] && nz_q[i];
            if (code_q == 4'(i + 1))   forced_valid_q = valid_q[i];
        end
    end

    // R4 / R7: a nonzero selection is always an input that was valid
    assert_sel_valid_R4: assert property (@(posedge clk) disable iff (rst || !seen)
        (sel_o != 4'd0) |-> valid_q[int'(sel_o) - 1]);

    assert_blocked_empty_R9: assert property (@(posedge clk) disable iff (rst || !seen)
        blocked_q |-> (sel_o == 4'd0 && rank1_o == 4'd0 && rank2_o == 4'd0 && rank3_o == 4'd0));

    assert_nonrev_hold_R4: assert property (@(posedge clk) disable iff (rst || !seen)
        (auto_q && !rev_q && prev_keepable) |-> (sel_o == sel_prev));

    assert_forced_rev_R7: assert property (@(posedge clk) disable iff (rst || !seen)
        (forced_q && rev_q && forced_valid_q) |-> (sel_o == code_q && rank1_o == code_q));

    assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (rst || !seen)
        ($past(upgrade_pend_o) && !$past(upgrade_clr_i)) |-> upgrade_pend_o);

    assert_rank_distinct_R2: assert property (@(posedge clk) disable iff (rst || !seen)
        (rank2_o != 4'd0) |-> (rank2_o != rank1_o && (rank3_o == 4'd0 ||
                               (rank3_o != rank2_o && rank3_o != rank1_o))));
endmodule

bind prio_ref_selector refsel_checker #(
    .NUM_IN     (NUM_IN),
    .PRIO_W     (PRIO_W),
    .FORCE_MASK (FORCE_MASK)
) u_chk (.*);

// File: tb/prio_ref_selector_tb_top.sv
`timescale 1ns/1ps
module prio_ref_selector_tb_top;
    localparam int N  = 9;
    localparam int PW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*PW-1:0] prio_i = '0;
    logic [N-1:0]    valid_i = '0;
    logic            revertive_i = 1'b0;
    logic [3:0]      force_i = '0;
    logic            upgrade_clr_i = 1'b0;
    logic            irq_en_i = 1'b0;
    logic [3:0]      sel_o, rank1_o, rank2_o, rank3_o;
    logic            upgrade_pend_o, irq_o;

    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    logic [3:0] pr [1:9];
    bit         vl [1:9];
    int         exp_sel = 0;
    bit         exp_pend = 0;
    int unsigned rnd = 32'h1234_5678;

    always #2.5 clk = ~clk;

    prio_ref_selector dut_i (
        .clk(clk), .rst(rst), .prio_i(prio_i), .valid_i(valid_i),
        .revertive_i(revertive_i), .force_i(force_i), .upgrade_clr_i(upgrade_clr_i),
        .irq_en_i(irq_en_i), .sel_o(sel_o), .rank1_o(rank1_o), .rank2_o(rank2_o),
        .rank3_o(rank3_o), .upgrade_pend_o(upgrade_pend_o), .irq_o(irq_o)
    );

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int unsigned xs(int unsigned x);
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Drive current bench state (at a falling edge), predict, clock, compare.
    task automatic step(string extra = "");
        int  fidx, best, nxt, key, bestkey, pick;
        bit  blocked, keep, setp;
        int  nr [3];
        int  er [3];
        bit  used [1:9];
        string rtag, stag;
        for (int i = 1; i <= 9; i++) begin
            prio_i[(i-1)*PW +: PW] = pr[i];
            valid_i[i-1] = vl[i];
            used[i] = 0;
        end
        fidx = 0;
        blocked = 0;
        if (force_i == 0 || force_i == 15) fidx = 0;
        else if ((force_i >= 1 && force_i <= 6) || force_i == 8 || force_i == 9) fidx = force_i;
        else blocked = 1;
        for (int r = 0; r < 3; r++) begin
            pick = 0;
            bestkey = 1 << 20;
            for (int i = 1; i <= 9; i++) begin
                key = int'(pr[i]) * 16 + i;
                if (vl[i] && pr[i] != 0 && i != fidx && !used[i] && key < bestkey) begin
                    bestkey = key;
                    pick = i;
                end
            end
            nr[r] = pick;
            if (pick != 0) used[pick] = 1;
        end
        if (blocked)        er = '{0, 0, 0};
        else if (fidx != 0) er = '{fidx, nr[0], nr[1]};
        else                er = nr;
        best = (fidx != 0 && vl[fidx]) ? fidx : nr[0];
        keep = exp_sel != 0 && vl[exp_sel] && (pr[exp_sel] != 0 || exp_sel == fidx);
        if (blocked)          nxt = 0;
        else if (revertive_i) nxt = best;
        else                  nxt = keep ? exp_sel : best;
        setp = !blocked && !revertive_i && keep && best != exp_sel;
        exp_pend = (exp_pend && !upgrade_clr_i) || setp;
        exp_sel = nxt;
        if (blocked)           begin rtag = "R9"; stag = "R9"; end
        else if (fidx != 0)    begin rtag = "R6"; stag = revertive_i ? "R7" : "R8"; end
        else if (force_i == 15) begin rtag = "R5"; stag = "R5"; end
        else                   begin rtag = "R2"; stag = revertive_i ? "R3" : "R4"; end
        @(posedge clk);
        #1;
        check({rtag, " rank1"}, rank1_o, er[0]);
        check({rtag, " rank2"}, rank2_o, er[1]);
        check({rtag, " rank3"}, rank3_o, er[2]);
        check({stag, " sel"}, sel_o, exp_sel);
        if (extra != "") check({extra, " sel"}, sel_o, exp_sel);
        check("R10 pending", upgrade_pend_o, exp_pend);
        check("R11 irq", irq_o, exp_pend && irq_en_i);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 1; i <= 9; i++) begin pr[i] = 4'd0; vl[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 sel", sel_o, 0);
        check("R1 rank1", rank1_o, 0);
        check("R1 rank2", rank2_o, 0);
        check("R1 rank3", rank3_o, 0);
        check("R1 pending", upgrade_pend_o, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 ties: equal priorities rank by input number
        for (int i = 1; i <= 9; i++) begin pr[i] = 4'd2; vl[i] = 1; end
        revertive_i = 1'b1;
        step("R2");
        check("R2 tie order", rank1_o * 100 + rank2_o * 10 + rank3_o, 123);

        // R2 distinct values, one zero priority
        pr[1] = 5; pr[2] = 3; pr[3] = 0; pr[4] = 3; pr[5] = 1;
        pr[6] = 7; pr[7] = 2; pr[8] = 9; pr[9] = 4;
        step("R3");
        check("R2 order", rank1_o * 100 + rank2_o * 10 + rank3_o, 572);

        // R10 / R12: nonrevertive hold, better input appears, clear, manual switchover
        revertive_i = 1'b0;
        irq_en_i = 1'b1;
        vl[5] = 0; vl[7] = 0;
        step("R4");
        vl[2] = 0;
        step("R4");
        vl[5] = 1;
        step("R4");
        check("R10 set", upgrade_pend_o, 1);
        check("R11 raised", irq_o, 1);
        upgrade_clr_i = 1'b1;
        step("R10");
        upgrade_clr_i = 1'b0;
        step("R4");
        revertive_i = 1'b1;
        step("R12");
        check("R12 moved", sel_o, 5);
        revertive_i = 1'b0;
        step("R12");
        check("R12 held", sel_o, 5);

        // Every force code in both policies, twice each
        for (int rv = 0; rv < 2; rv++) begin
            for (int fc = 0; fc < 16; fc++) begin
                revertive_i = rv[0];
                force_i = 4'(fc);
                step();
                step();
            end
        end
        force_i = 4'd0;

        // Pseudo-random run
        for (int n = 0; n < 4000; n++) begin
            rnd = xs(rnd);
            if (n % 16 == 0) begin
                for (int i = 1; i <= 9; i++) pr[i] = 4'((rnd >> (2 * i)) & 3);
                rnd = xs(rnd);
            end
            for (int i = 1; i <= 9; i++) vl[i] = ((rnd >> (2 * i)) & 3) != 0;
            rnd = xs(rnd);
            force_i = (rnd[3:0] < 4'd11) ? 4'd0 : rnd[7:4];
            if (rnd[11:8] == 4'd0) revertive_i = ~revertive_i;
            upgrade_clr_i = rnd[12] & rnd[13];
            irq_en_i = rnd[14] | rnd[15];
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule